// File: doc/BRIEF.md
# Chained Vector Multiply-Add Unit

This block is a compact vector execution engine. It holds a bank of eight vector registers of 64 signed 32-bit elements. An instruction names two source registers, one destination register, a length and a scalar. The unit then streams the elements, one per clock, through a three-stage multiplier. The multiplier feeds a two-stage adder element by element. Because the product of each element enters the adder in the cycle after it leaves the multiplier, a fused scalar-multiply-add finishes in the pipeline depth plus the vector length, not twice that.

Four operations share the single datapath. The multiplier's second operand is the second source register or the scalar. The adder's addend is the second source register or zero. A preload port fills registers before a run. A combinational read port lets the results be inspected. A one-cycle `done` pulse marks the end of each instruction.

The instruction port is valid/ready. An instruction is taken on a rising clock edge where `instr_valid` and `instr_ready` are both high. `instr_ready` falls on that edge and stays low until the cycle in which `done` is high. While `instr_ready` is low, the sender must hold its instruction, and the unit neither samples it nor acts on it. The preload, read and done pins are plain signals with no handshake.

Top module: `vec_chain_unit`

## Requirements
- R1: The register bank has eight registers (index 0..7) of 64 elements (index 0..63), each 32 bits wide. A preload write (`wr_en` high at a clock edge while `instr_ready` is high) stores `wr_data` at `wr_reg`/`wr_idx`. `rd_data` always shows element `rd_idx` of register `rd_reg`, combinationally.
- R2: Opcode 0 (element product): dst(i) = A(i) * B(i), keeping the low 32 bits.
- R3: Opcode 1 (scalar multiply-add): dst(i) = s * A(i) + B(i) modulo 2^32, where s is `instr_scalar`.
- R4: Opcode 2 (element sum) gives dst(i) = A(i) + B(i). Opcode 3 (scale) gives dst(i) = s * A(i). Both wrap modulo 2^32.
- R5: With a length n in 1..64, only elements 0..n-1 of the destination are written, and every other element and register keeps its value. A length field above 64 acts as 64.
- R6: A length of 0 writes nothing, raises `done` in the cycle that follows the accepting edge, and leaves `instr_ready` high.
- R7: For n >= 1, one element enters the pipeline every cycle with no gaps. Element k is written on the (k+6)-th edge after the accepting edge. `done` is high for exactly the one cycle that follows the final write, which is n+5 edges after acceptance.
- R8: `instr_ready` is low from the accepting edge until the `done` cycle. An instruction offered while it is low is never taken and has no effect.
- R9: A preload write offered while `instr_ready` is low is ignored.
- R10: The destination may be the same register as either source. Each result is then computed from the source values held before the instruction began.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| instr_valid | input | 1 | Instruction offered |
| instr_ready | output | 1 | Unit idle, instruction can be taken |
| instr_op | input | 2 | Opcode 0..3 |
| instr_dst | input | 3 | Destination register |
| instr_src_a | input | 3 | First source register |
| instr_src_b | input | 3 | Second source register |
| instr_len | input | 7 | Vector length, 0..127 (above 64 treated as 64) |
| instr_scalar | input | 32 | Scalar operand s |
| wr_en | input | 1 | Preload write enable |
| wr_reg | input | 3 | Preload register |
| wr_idx | input | 6 | Preload element |
| wr_data | input | 32 | Preload data |
| rd_reg | input | 3 | Read register |
| rd_idx | input | 6 | Read element |
| rd_data | output | 32 | Read data |
| done | output | 1 | One-cycle end-of-instruction pulse |

## Verification
The bench targets the following corner cases, and each one traps a particular kind of fault.
- **Timing:** a cycle-exact completion count for lengths 1, 17 and 64. It catches a pipeline that has a stage too many or too few, and a `done` that is raised on the wrong element.
- **Over-long and zero-length runs:** a length of 100 catches a missing clamp, which would write junk past the register or wrap the index. A length of 0 catches a unit that writes element 0 anyway or that locks up.
- **Aliasing:** a multiply-add whose destination is also its source catches writeback that overtakes the reads.
- **Arithmetic edges:** large negative products catch errors in truncation and sign handling.
- **Requests while busy:** an instruction and a preload are both offered while the unit is busy. The bench then reads the registers those two requests name, which would have changed if the handshake or the preload gate leaked.

// File: rtl/vcu_pkg.sv
package vcu_pkg;

  typedef enum logic [1:0] {
    OP_VMUL = 2'd0,
    OP_VSMA = 2'd1,
    OP_VADD = 2'd2,
    OP_VSCL = 2'd3
  } vop_e;

  localparam int DEF_NREG    = 8;
  localparam int DEF_NELEM   = 64;
  localparam int DEF_DW      = 32;
  localparam int DEF_MUL_LAT = 3;
  localparam int DEF_ADD_LAT = 2;

endpackage

// File: rtl/vcu_vrf.sv
module vcu_vrf #(
  parameter int NREG  = 8,
  parameter int NELEM = 64,
  parameter int DW    = 32,
  localparam int RW   = $clog2(NREG),
  localparam int EW   = $clog2(NELEM),
  localparam int AW   = RW + EW
) (
  input  logic          clk,
  input  logic [RW-1:0] ra_reg,
  input  logic [EW-1:0] ra_idx,
  output logic [DW-1:0] ra_data,
  input  logic [RW-1:0] rb_reg,
  input  logic [EW-1:0] rb_idx,
  output logic [DW-1:0] rb_data,
  input  logic [RW-1:0] rc_reg,
  input  logic [EW-1:0] rc_idx,
  output logic [DW-1:0] rc_data,
  input  logic          wb_we,
  input  logic [RW-1:0] wb_reg,
  input  logic [EW-1:0] wb_idx,
  input  logic [DW-1:0] wb_data,
  input  logic          pl_we,
  input  logic [RW-1:0] pl_reg,
  input  logic [EW-1:0] pl_idx,
  input  logic [DW-1:0] pl_data
);

  localparam int DEPTH = NREG * NELEM;

  logic [DW-1:0] mem_q [DEPTH];

  // pipeline writeback wins over preload when both are present
  always_ff @(posedge clk) begin
    if (wb_we) begin
      mem_q[AW'({wb_reg, wb_idx})] <= wb_data;
    end else if (pl_we) begin
      mem_q[AW'({pl_reg, pl_idx})] <= pl_data;
    end
  end

  assign ra_data = mem_q[AW'({ra_reg, ra_idx})];
  assign rb_data = mem_q[AW'({rb_reg, rb_idx})];
  assign rc_data = mem_q[AW'({rc_reg, rc_idx})];

endmodule

// File: rtl/vcu_mul_pipe.sv
module vcu_mul_pipe #(
  parameter int DW  = 32,
  parameter int EW  = 6,
  parameter int LAT = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          in_last,
  input  logic [EW-1:0] in_idx,
  input  logic [DW-1:0] in_x,
  input  logic [DW-1:0] in_y,
  input  logic [DW-1:0] in_addend,
  output logic          out_valid,
  output logic          out_last,
  output logic [EW-1:0] out_idx,
  output logic [DW-1:0] out_prod,
  output logic [DW-1:0] out_addend
);

  logic [LAT-1:0] vld_q;
  logic [LAT-1:0] last_q;
  logic [EW-1:0]  idx_q  [LAT];
  logic [DW-1:0]  prod_q [LAT];
  logic [DW-1:0]  add_q  [LAT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= '0;
      last_q <= '0;
    end else begin
      vld_q[0]  <= in_valid;
      last_q[0] <= in_valid & in_last;
      for (int s = 1; s < LAT; s++) begin
        vld_q[s]  <= vld_q[s-1];
        last_q[s] <= last_q[s-1];
      end
    end
  end

  // stage 0 forms the truncated product, later stages only carry it
  always_ff @(posedge clk) begin
    prod_q[0] <= in_x * in_y;
    add_q[0]  <= in_addend;
    idx_q[0]  <= in_idx;
    for (int s = 1; s < LAT; s++) begin
      prod_q[s] <= prod_q[s-1];
      add_q[s]  <= add_q[s-1];
      idx_q[s]  <= idx_q[s-1];
    end
  end

  assign out_valid  = vld_q[LAT-1];
  assign out_last   = last_q[LAT-1];
  assign out_idx    = idx_q[LAT-1];
  assign out_prod   = prod_q[LAT-1];
  assign out_addend = add_q[LAT-1];

endmodule

// File: rtl/vcu_add_pipe.sv
module vcu_add_pipe #(
  parameter int DW  = 32,
  parameter int EW  = 6,
  parameter int LAT = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          in_last,
  input  logic [EW-1:0] in_idx,
  input  logic [DW-1:0] in_a,
  input  logic [DW-1:0] in_b,
  output logic          out_valid,
  output logic          out_last,
  output logic [EW-1:0] out_idx,
  output logic [DW-1:0] out_sum
);

  logic [LAT-1:0] vld_q;
  logic [LAT-1:0] last_q;
  logic [EW-1:0]  idx_q [LAT];
  logic [DW-1:0]  sum_q [LAT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= '0;
      last_q <= '0;
    end else begin
      vld_q[0]  <= in_valid;
      last_q[0] <= in_valid & in_last;
      for (int s = 1; s < LAT; s++) begin
        vld_q[s]  <= vld_q[s-1];
        last_q[s] <= last_q[s-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    sum_q[0] <= in_a + in_b;
    idx_q[0] <= in_idx;
    for (int s = 1; s < LAT; s++) begin
      sum_q[s] <= sum_q[s-1];
      idx_q[s] <= idx_q[s-1];
    end
  end

  assign out_valid = vld_q[LAT-1];
  assign out_last  = last_q[LAT-1];
  assign out_idx   = idx_q[LAT-1];
  assign out_sum   = sum_q[LAT-1];

endmodule

// File: rtl/vcu_seq.sv
module vcu_seq #(
  parameter int NELEM = 64,
  localparam int EW   = $clog2(NELEM),
  localparam int LW   = EW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          instr_valid,
  input  logic [LW-1:0] instr_len,
  input  logic          wb_valid,
  input  logic          wb_last,
  output logic          instr_ready,
  output logic          accept,
  output logic          iss_valid,
  output logic          iss_last,
  output logic [EW-1:0] iss_idx,
  output logic          done
);

  logic          busy_q;
  logic          issuing_q;
  logic [EW-1:0] idx_q;
  logic [LW-1:0] len_q;
  logic [LW-1:0] eff_len;
  logic          finish;

  assign instr_ready = ~busy_q;
  assign accept      = instr_valid & ~busy_q;
  assign eff_len     = (instr_len > LW'(NELEM)) ? LW'(NELEM) : instr_len;
  assign iss_valid   = issuing_q;
  assign iss_idx     = idx_q;
  assign iss_last    = issuing_q & ({1'b0, idx_q} == (len_q - LW'(1)));
  assign finish      = wb_valid & wb_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      issuing_q <= 1'b0;
      idx_q     <= '0;
      len_q     <= '0;
      done      <= 1'b0;
    end else begin
      done <= finish | (accept & (eff_len == '0));
      if (accept && eff_len != '0) begin
        busy_q    <= 1'b1;
        issuing_q <= 1'b1;
        idx_q     <= '0;
        len_q     <= eff_len;
      end else begin
        if (issuing_q) begin
          idx_q <= idx_q + EW'(1);
          if (iss_last) issuing_q <= 1'b0;
        end
        if (finish) busy_q <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/vec_chain_unit.sv
module vec_chain_unit
  import vcu_pkg::*;
#(
  parameter int NREG    = DEF_NREG,
  parameter int NELEM   = DEF_NELEM,
  parameter int DW      = DEF_DW,
  parameter int MUL_LAT = DEF_MUL_LAT,
  parameter int ADD_LAT = DEF_ADD_LAT,
  localparam int RW     = $clog2(NREG),
  localparam int EW     = $clog2(NELEM),
  localparam int LW     = EW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          instr_valid,
  output logic          instr_ready,
  input  logic [1:0]    instr_op,
  input  logic [RW-1:0] instr_dst,
  input  logic [RW-1:0] instr_src_a,
  input  logic [RW-1:0] instr_src_b,
  input  logic [LW-1:0] instr_len,
  input  logic [DW-1:0] instr_scalar,
  input  logic          wr_en,
  input  logic [RW-1:0] wr_reg,
  input  logic [EW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic [RW-1:0] rd_reg,
  input  logic [EW-1:0] rd_idx,
  output logic [DW-1:0] rd_data,
  output logic          done
);

  // latched instruction fields
  vop_e          op_q;
  logic [RW-1:0] dst_q, src_a_q, src_b_q;
  logic [DW-1:0] scalar_q;

  logic          accept;
  logic          iss_valid, iss_last;
  logic [EW-1:0] iss_idx;

  logic [DW-1:0] opa, opb;
  logic [DW-1:0] mul_y, addend;

  logic          m_valid, m_last;
  logic [EW-1:0] m_idx;
  logic [DW-1:0] m_prod, m_addend;

  logic          wb_valid, wb_last;
  logic [EW-1:0] wb_idx;
  logic [DW-1:0] wb_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q     <= OP_VMUL;
      dst_q    <= '0;
      src_a_q  <= '0;
      src_b_q  <= '0;
      scalar_q <= '0;
    end else if (accept) begin
      op_q     <= vop_e'(instr_op);
      dst_q    <= instr_dst;
      src_a_q  <= instr_src_a;
      src_b_q  <= instr_src_b;
      scalar_q <= instr_scalar;
    end
  end

  vcu_seq #(.NELEM(NELEM)) seq_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .instr_valid(instr_valid),
    .instr_len  (instr_len),
    .wb_valid   (wb_valid),
    .wb_last    (wb_last),
    .instr_ready(instr_ready),
    .accept     (accept),
    .iss_valid  (iss_valid),
    .iss_last   (iss_last),
    .iss_idx    (iss_idx),
    .done       (done)
  );

  vcu_vrf #(.NREG(NREG), .NELEM(NELEM), .DW(DW)) vrf_i (
    .clk    (clk),
    .ra_reg (src_a_q),
    .ra_idx (iss_idx),
    .ra_data(opa),
    .rb_reg (src_b_q),
    .rb_idx (iss_idx),
    .rb_data(opb),
    .rc_reg (rd_reg),
    .rc_idx (rd_idx),
    .rc_data(rd_data),
    .wb_we  (wb_valid),
    .wb_reg (dst_q),
    .wb_idx (wb_idx),
    .wb_data(wb_data),
    .pl_we  (wr_en & instr_ready),
    .pl_reg (wr_reg),
    .pl_idx (wr_idx),
    .pl_data(wr_data)
  );

  // operand routing: every opcode uses the same multiply-then-add path
  always_comb begin
    unique case (op_q)
      OP_VMUL: begin mul_y = opb;      addend = '0;  end
      OP_VSMA: begin mul_y = scalar_q; addend = opb; end
      OP_VADD: begin mul_y = DW'(1);   addend = opb; end
      default: begin mul_y = scalar_q; addend = '0;  end
    endcase
  end

  vcu_mul_pipe #(.DW(DW), .EW(EW), .LAT(MUL_LAT)) mul_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (iss_valid),
    .in_last   (iss_last),
    .in_idx    (iss_idx),
    .in_x      (opa),
    .in_y      (mul_y),
    .in_addend (addend),
    .out_valid (m_valid),
    .out_last  (m_last),
    .out_idx   (m_idx),
    .out_prod  (m_prod),
    .out_addend(m_addend)
  );

  // chained: each product enters the adder the cycle it emerges
  vcu_add_pipe #(.DW(DW), .EW(EW), .LAT(ADD_LAT)) add_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (m_valid),
    .in_last  (m_last),
    .in_idx   (m_idx),
    .in_a     (m_prod),
    .in_b     (m_addend),
    .out_valid(wb_valid),
    .out_last (wb_last),
    .out_idx  (wb_idx),
    .out_sum  (wb_data)
  );

endmodule

// File: rtl/vcu_checker.sv
module vcu_checker #(
  parameter int EW = 6,
  parameter int LW = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          instr_valid,
  input logic          instr_ready,
  input logic [LW-1:0] instr_len,
  input logic          done,
  input logic          iss_valid,
  input logic          iss_last,
  input logic          wb_valid,
  input logic          wb_last,
  input logic [EW-1:0] wb_idx
);

  // R7: elements issue back to back until the last one
  a_r7_issue_gapless: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && !iss_last) |=> iss_valid);

  // R7: writebacks arrive in ascending element order, one per cycle
  a_r7_wb_in_order: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && !wb_last) |=> (wb_valid && wb_idx == $past(wb_idx) + EW'(1)));

  // R7 / R6: done only follows a final write or a zero-length accept
  a_r7_done_cause: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(wb_valid && wb_last) ||
              $past(instr_valid && instr_ready && instr_len == '0)));

  // R8: no instruction is taken while results are still being written
  a_r8_ready_low_inflight: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> !instr_ready);

  // R6: a zero-length run produces no writeback next cycle
  a_r6_zero_len_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && instr_ready && instr_len == '0 && !wb_valid) |=> !wb_valid);

endmodule

bind vec_chain_unit vcu_checker #(.EW(EW), .LW(LW)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .instr_valid(instr_valid),
  .instr_ready(instr_ready),
  .instr_len  (instr_len),
  .done       (done),
  .iss_valid  (iss_valid),
  .iss_last   (iss_last),
  .wb_valid   (wb_valid),
  .wb_last    (wb_last),
  .wb_idx     (wb_idx)
);

// File: tb/vec_chain_unit_tb_top.sv
`timescale 1ns/1ps
module vec_chain_unit_tb_top;

  typedef struct {
    int          r;
    int          i;
    logic [31:0] v;
    string       req;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        instr_valid = 1'b0;
  logic        instr_ready;
  logic [1:0]  instr_op = '0;
  logic [2:0]  instr_dst = '0, instr_src_a = '0, instr_src_b = '0;
  logic [6:0]  instr_len = '0;
  logic [31:0] instr_scalar = '0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_reg = '0;
  logic [5:0]  wr_idx = '0;
  logic [31:0] wr_data = '0;
  logic [2:0]  rd_reg = '0;
  logic [5:0]  rd_idx = '0;
  logic [31:0] rd_data;
  logic        done;

  int total = 0;
  int bad   = 0;
  logic [31:0] mdl [8][64];
  item_t sb_q[$];
  event chk_ev, mon_done;

  always #5 clk = ~clk;

  vec_chain_unit dut_i (
    .clk(clk), .rst_n(rst_n),
    .instr_valid(instr_valid), .instr_ready(instr_ready),
    .instr_op(instr_op), .instr_dst(instr_dst),
    .instr_src_a(instr_src_a), .instr_src_b(instr_src_b),
    .instr_len(instr_len), .instr_scalar(instr_scalar),
    .wr_en(wr_en), .wr_reg(wr_reg), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_reg(rd_reg), .rd_idx(rd_idx), .rd_data(rd_data), .done(done)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pops expected items and compares against the read port
  initial begin
    forever begin
      @(chk_ev);
      while (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        rd_reg = it.r[2:0];
        rd_idx = it.i[5:0];
        #1;
        check(rd_data === it.v, it.req, rd_data, it.v);
      end
      ->mon_done;
    end
  end

  task automatic push_reg(input int r, input string req);
    for (int i = 0; i < 64; i++) begin
      item_t it;
      it.r = r; it.i = i; it.v = mdl[r][i]; it.req = req;
      sb_q.push_back(it);
    end
  endtask

  task automatic verify();
    ->chk_ev;
    @(mon_done);
  endtask

  task automatic preload(input int r, input int i, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_reg = r[2:0]; wr_idx = i[5:0]; wr_data = d;
    @(posedge clk);
    #1 wr_en = 1'b0;
    mdl[r][i] = d;
  endtask

  // driver: runs one instruction, updates the model, queues expectations
  task automatic run_op(input int op, input int dst, input int a, input int b,
                        input int len, input logic [31:0] s, input bit poke,
                        input string req);
    logic [31:0] old_a [64];
    logic [31:0] old_b [64];
    int n;
    int cnt;
    int exp_cnt;
    n = (len > 64) ? 64 : len;
    for (int i = 0; i < 64; i++) begin
      old_a[i] = mdl[a][i];
      old_b[i] = mdl[b][i];
    end
    for (int i = 0; i < n; i++) begin
      case (op)
        0: mdl[dst][i] = old_a[i] * old_b[i];
        1: mdl[dst][i] = s * old_a[i] + old_b[i];
        2: mdl[dst][i] = old_a[i] + old_b[i];
        default: mdl[dst][i] = s * old_a[i];
      endcase
    end
    @(negedge clk);
    instr_valid = 1'b1; instr_op = op[1:0]; instr_dst = dst[2:0];
    instr_src_a = a[2:0]; instr_src_b = b[2:0]; instr_len = len[6:0];
    instr_scalar = s;
    @(posedge clk);
    cnt = 0;
    do begin
      @(negedge clk);
      cnt++;
      if (cnt == 1) begin
        instr_valid = 1'b0;
        if (n > 0) check(instr_ready == 1'b0, "R8 ready low after accept",
                         32'(instr_ready), 32'd0);
        else check(instr_ready == 1'b1, "R6 ready stays high",
                   32'(instr_ready), 32'd1);
        if (poke) begin
          // offered while busy: must be ignored (R8, R9)
          instr_valid = 1'b1; instr_op = 2'd2; instr_dst = 3'd7;
          instr_src_a = 3'd0; instr_src_b = 3'd1; instr_len = 7'd64;
          wr_en = 1'b1; wr_reg = 3'd6; wr_idx = 6'd3; wr_data = 32'hDEAD_BEEF;
        end
      end
      if (cnt == 3 && poke) begin
        instr_valid = 1'b0;
        wr_en = 1'b0;
      end
    end while (!done && cnt < 200);
    exp_cnt = (n == 0) ? 1 : n + 6;
    check(cnt == exp_cnt, {req, " R7 done timing"}, 32'(cnt), 32'(exp_cnt));
    check(instr_ready == 1'b1, {req, " R8 ready in done cycle"},
          32'(instr_ready), 32'd1);
    @(negedge clk);
    check(done == 1'b0, {req, " R7 done one cycle"}, 32'(done), 32'd0);
    push_reg(dst, req);
    if (poke) begin
      push_reg(7, "R8 ignored instruction");
      push_reg(6, "R9 ignored preload");
    end
    verify();
  endtask

  initial begin
    #2_000_000;
    bad++;
    total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(instr_ready == 1'b1, "reset ready", 32'(instr_ready), 32'd1);
    check(done == 1'b0, "reset done", 32'(done), 32'd0);
    rst_n = 1'b1;

    // R1: fill every register, then read it all back
    for (int r = 0; r < 8; r++)
      for (int i = 0; i < 64; i++)
        preload(r, i, 32'((r * 1000 + i * 37) ^ (i[0] ? 32'hF000_0000 : 32'h0))
                       - 32'(r * 7));
    preload(0, 5, 32'h7FFF_FFFF);
    preload(1, 5, 32'h8000_0001);
    for (int r = 0; r < 8; r++) push_reg(r, "R1 preload readback");
    verify();

    run_op(0, 2, 0, 1, 64, 32'd0, 1'b0, "R2 element product");
    run_op(1, 3, 0, 1, 64, 32'hFFFF_FFFD, 1'b0, "R3 scalar multiply-add");
    run_op(2, 4, 1, 2, 17, 32'd0, 1'b0, "R4 element sum len17 R5");
    run_op(3, 5, 0, 0, 64, 32'd12345, 1'b0, "R4 scale");
    run_op(2, 6, 3, 5, 100, 32'd0, 1'b0, "R5 length clamp");
    run_op(0, 7, 0, 1, 0, 32'd0, 1'b0, "R6 zero length");
    run_op(1, 4, 2, 3, 1, 32'd9, 1'b0, "R7 single element");
    run_op(1, 0, 0, 0, 64, 32'd5, 1'b0, "R10 alias dst=src");
    run_op(0, 2, 1, 1, 10, 32'd0, 1'b1, "R8 R9 busy requests");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule